// File: doc/BRIEF.md
# Pixel Word Serializer

This block turns one parallel pixel word per pixel-clock period into a 30-bit serial frame. Each frame holds 24 colour bits, the three timing flags (vertical sync, horizontal sync, data enable), an odd parity bit and two reserved zero bits. The block runs entirely from one fast bit clock. The bit clock is 30 times the pixel rate when one lane is used and 15 times the pixel rate when two lanes are used. The incoming pixel clock is treated as a data signal. It is synchronized, its capture edge is detected in the bit-clock domain, and each detected edge loads a new frame into the shifter.

Alongside the lanes the block drives a regenerated pixel clock. A 24-bit input bus can be taken as it is or fully bit-reversed, which lets the board route the bus in either order. When no capture edge arrives for a while, the block parks in standby with every output low.

The control logic is a two-state machine. In STANDBY the outputs are quiet. In SHIFT the frame is moving out. There are three transitions. WAKE goes from STANDBY to SHIFT on a capture edge. RELOAD stays in SHIFT and loads a new frame on each further capture edge. IDLE_OUT goes from SHIFT to STANDBY once the idle counter reaches the timeout without a capture edge.

Top module: `pixser_top`

## Requirements
- R1: During reset and directly after it, `standby` is 1 and `lane0`, `lane1` and `clk_out` are 0.
- R2: Frame bit 29 is sent first and bit 0 last. Bits 29..6 carry the pixel word (bit 29 = pixel bit 23). Bit 5 is vsync, bit 4 is hsync, bit 3 is data enable, bit 2 is parity. Bits 1..0 are always 0.
- R3: Parity is odd. The 27 data bits (pixel word and the three flags) together with the parity bit hold an odd number of ones.
- R4: With `swap_en`=0 the pixel word equals `pix_bus` (red 23:16, green 15:8, blue 7:0). With `swap_en`=1, pixel word bit i equals `pix_bus[23-i]`. The three flags are not moved in either case.
- R5: With `two_lane`=0, `lane0` carries frame bits 29..0, one per bit clock, and `lane1` stays 0.
- R6: With `two_lane`=1, over 15 bit clocks `lane0` carries frame bits 29..15 and `lane1` carries frame bits 14..0.
- R7: With `edge_sel`=0 only rising `pix_clk` edges capture data. With `edge_sel`=1 only falling edges capture data. The other edge has no effect.
- R8: The first bit of a frame is on the lanes right after the third rising `bit_clk` edge that follows the capture transition of `pix_clk` (two synchronizer stages plus the load).
- R9: `clk_out` is high for the first ceil(P/2) bits of each frame and low for the rest, where P is 30 (one lane) or 15 (two lanes).
- R10: If no capture edge arrives within 64 bit clocks of the last frame load, `standby` goes to 1 and all three outputs are held at 0. Changes on the data inputs then have no effect on the outputs.
- R11: The first capture edge in standby clears `standby` in the same cycle as the first frame bit appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Fast bit clock, P times the pixel rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_clk | input | 1 | Incoming pixel clock, sampled as data |
| edge_sel | input | 1 | Capture edge: 0 rising, 1 falling |
| swap_en | input | 1 | 1 bit-reverses the 24-bit pixel bus |
| two_lane | input | 1 | 0 one lane (30 bits/pixel), 1 two lanes (15 bits/pixel) |
| pix_bus | input | 24 | Parallel pixel bits |
| vsync | input | 1 | Vertical sync flag |
| hsync | input | 1 | Horizontal sync flag |
| den | input | 1 | Data enable flag |
| lane0 | output | 1 | Serial lane 0 |
| lane1 | output | 1 | Serial lane 1 (two-lane mode only) |
| clk_out | output | 1 | Regenerated pixel clock |
| standby | output | 1 | High while the pixel clock is absent |

## Verification
The bench goes after the frame boundary, where one frame's tail meets the next frame's head three bit clocks after each pixel edge. A design with the wrong synchronizer depth or load timing shows a shifted bit stream there. All-zero and all-one words check the parity sense: an even-parity design gives the wrong bit 2 on both. A single set bus bit under swap shows up at the wrong frame position if the reversal is wrong. The edge the mode should ignore is applied while the block is in standby, so a design that captures on both edges wakes up when it should not. The stop of the pixel clock is probed both before and after the timeout. This catches a design that never sleeps, one that sleeps too early, and one that leaks data onto the lanes while asleep.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
    localparam int PIX_W   = 24;
    localparam int CTRL_W  = 3;
    localparam int RSV_W   = 2;
    localparam int FRAME_W = PIX_W + CTRL_W + 1 + RSV_W;

    typedef enum logic {
        ST_STANDBY = 1'b0,
        ST_SHIFT   = 1'b1
    } pixser_state_t;
endpackage

// File: rtl/pixser_edge_sync.sv
module pixser_edge_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic falling_sel,
    output logic cap
);
    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] sh_q;
    logic            rise_w;
    logic            fall_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], pix_clk};
    end

    assign rise_w = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    assign fall_w = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
    assign cap    = falling_sel ? fall_w : rise_w;

    // R7
    no_double_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !cap);
endmodule

// File: rtl/pixser_frame.sv
module pixser_frame
    import pixser_pkg::*;
(
    input  logic [PIX_W-1:0]   pix_bus,
    input  logic               swap_en,
    input  logic               vsync,
    input  logic               hsync,
    input  logic               den,
    output logic [FRAME_W-1:0] frame
);
    logic [PIX_W-1:0] rev_w;
    logic [PIX_W-1:0] pix_w;
    logic             par_w;

    for (genvar i = 0; i < PIX_W; i++) begin : g_rev
        assign rev_w[i] = pix_bus[PIX_W-1-i];
    end

    assign pix_w = swap_en ? rev_w : pix_bus;
    assign par_w = ~(^{pix_w, vsync, hsync, den});
    assign frame = {pix_w, vsync, hsync, den, par_w, {RSV_W{1'b0}}};
endmodule

// File: rtl/pixser_top.sv
module pixser_top
    import pixser_pkg::*;
#(
    parameter int TIMEOUT = 64,
    parameter int SYNC_N  = 2
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             pix_clk,
    input  logic             edge_sel,
    input  logic             swap_en,
    input  logic             two_lane,
    input  logic [PIX_W-1:0] pix_bus,
    input  logic             vsync,
    input  logic             hsync,
    input  logic             den,
    output logic             lane0,
    output logic             lane1,
    output logic             clk_out,
    output logic             standby
);
    localparam int CW       = $clog2(TIMEOUT + 1);
    localparam int HALF_ONE = (FRAME_W + 1) / 2;
    localparam int HALF_TWO = (FRAME_W / 2 + 1) / 2;
    localparam int LANE1_B  = FRAME_W / 2 - 1;

    pixser_state_t      state_q, state_d;
    logic               cap;
    logic [FRAME_W-1:0] frame_w;
    logic [FRAME_W-1:0] shreg_q;
    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      half_lim;
    logic               idle_end;

    pixser_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .pix_clk     (pix_clk),
        .falling_sel (edge_sel),
        .cap         (cap)
    );

    pixser_frame u_frame (
        .pix_bus (pix_bus),
        .swap_en (swap_en),
        .vsync   (vsync),
        .hsync   (hsync),
        .den     (den),
        .frame   (frame_w)
    );

    assign idle_end = (cnt_q == CW'(TIMEOUT - 1));
    assign half_lim = two_lane ? CW'(HALF_TWO) : CW'(HALF_ONE);

    // state register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // transitions: WAKE, RELOAD, IDLE_OUT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: if (cap) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (cap)           state_d = ST_SHIFT;
                else if (idle_end) state_d = ST_STANDBY;
            end
            default:               state_d = ST_STANDBY;
        endcase
    end

    // shifter and idle counter
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (cap) begin
            shreg_q <= frame_w;
            cnt_q   <= '0;
        end else if (state_q == ST_SHIFT) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            if (!idle_end) cnt_q <= cnt_q + 1'b1;
        end else begin
            shreg_q <= '0;
        end
    end

    // outputs
    always_comb begin
        lane0   = 1'b0;
        lane1   = 1'b0;
        clk_out = 1'b0;
        standby = 1'b1;
        unique case (state_q)
            ST_STANDBY: standby = 1'b1;
            ST_SHIFT: begin
                standby = 1'b0;
                lane0   = shreg_q[FRAME_W-1];
                lane1   = two_lane & shreg_q[LANE1_B];
                clk_out = (cnt_q < half_lim);
            end
            default:    standby = 1'b1;
        endcase
    end

    // R11
    wake_clears_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (state_q == ST_STANDBY && cap) |=> !standby);

    // R3
    odd_parity_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cap |=> (^shreg_q[FRAME_W-1:RSV_W]) == 1'b1);

    // R2
    rsv_zero_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cap |=> shreg_q[RSV_W-1:0] == '0);

    // R9
    clk_rise_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(clk_out) |-> $past(cap));

    // R10
    quiet_standby_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        standby |-> (!lane0 && !lane1 && !clk_out));

    // R5
    one_lane_quiet_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !two_lane |-> !lane1);
endmodule

// File: tb/pixser_top_bench.sv
module pixser_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        bit_clk = 1'b0;
    logic        rst_n;
    logic        pix_clk;
    logic        edge_sel;
    logic        swap_en;
    logic        two_lane;
    logic [23:0] pix_bus;
    logic        vsync;
    logic        hsync;
    logic        den;
    logic        lane0;
    logic        lane1;
    logic        clk_out;
    logic        standby;

    int          checks = 0;
    int          fails  = 0;
    logic [29:0] prev_frame;
    bit          prev_valid;
    int          seed_dummy;

    pixser_top u_pixser_top (
        .bit_clk (bit_clk), .rst_n (rst_n), .pix_clk (pix_clk),
        .edge_sel (edge_sel), .swap_en (swap_en), .two_lane (two_lane),
        .pix_bus (pix_bus), .vsync (vsync), .hsync (hsync), .den (den),
        .lane0 (lane0), .lane1 (lane1), .clk_out (clk_out), .standby (standby)
    );

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [29:0] exp_frame(input logic [23:0] bus, input logic sw,
                                              input logic v, input logic h, input logic d);
        logic [23:0] p;
        logic        par;
        for (int i = 0; i < 24; i++) p[i] = sw ? bus[23-i] : bus[i];
        par = 1'b1;
        for (int i = 0; i < 24; i++) par = par ^ p[i];
        par = par ^ v ^ h ^ d;
        return {p, v, h, d, par, 2'b00};
    endfunction

    task automatic send_pix(input logic [23:0] bus, input logic v, input logic h, input logic d);
        int          per;
        int          hp;
        int          b;
        logic [29:0] cur;
        logic [29:0] src;
        per = two_lane ? 15 : 30;
        hp  = (per + 1) / 2;
        cur = exp_frame(bus, swap_en, v, h, d);
        for (int t = 0; t < per; t++) begin
            @(negedge bit_clk);
            if (t == 0) begin
                pix_bus = bus; vsync = v; hsync = h; den = d;
                pix_clk = edge_sel ? 1'b0 : 1'b1;
            end
            if (t == hp) pix_clk = edge_sel ? 1'b1 : 1'b0;
            b = -1;
            if (t >= 3) begin
                b = t - 3; src = cur;
            end else if (prev_valid) begin
                b = per - 3 + t; src = prev_frame;
            end else begin
                chk("R11 standby before first bit", {31'd0, standby}, 32'd1);
                chk("R8 lane0 before first bit", {31'd0, lane0}, 32'd0);
            end
            if (t == 3 && !prev_valid)
                chk("R11 standby cleared with first bit", {31'd0, standby}, 32'd0);
            if (b >= 0) begin
                chk(b == 0 ? "R8 R2 R3 R4 lane0 first bit" :
                    (two_lane ? "R6 R2 R3 R4 lane0 bit" : "R5 R2 R3 R4 lane0 bit"),
                    {31'd0, lane0}, {31'd0, src[29-b]});
                chk(two_lane ? "R6 lane1 bit" : "R5 lane1 idle",
                    {31'd0, lane1}, two_lane ? {31'd0, src[14-b]} : 32'd0);
                chk("R9 clk_out", {31'd0, clk_out}, {31'd0, (b < hp)});
            end
        end
        prev_frame = cur;
        prev_valid = 1'b1;
    endtask

    task automatic go_idle();
        int per;
        per = two_lane ? 15 : 30;
        for (int t = per; t < 100; t++) begin
            @(negedge bit_clk);
            if (t > 60) begin
                pix_bus = $urandom; vsync = $urandom; hsync = $urandom; den = $urandom;
            end
            if (t == 40) chk("R10 no standby before timeout", {31'd0, standby}, 32'd0);
        end
        chk("R10 standby after timeout", {31'd0, standby}, 32'd1);
        chk("R10 outputs quiet in standby", {29'd0, lane0, lane1, clk_out}, 32'd0);
        prev_valid = 1'b0;
    endtask

    task automatic wait_check_ignored(input string req);
        for (int t = 0; t < 12; t++) @(negedge bit_clk);
        chk(req, {28'd0, standby, lane0, lane1, clk_out}, 32'h8);
    endtask

    task automatic rand_pixels(input int n);
        for (int i = 0; i < n; i++)
            send_pix($urandom, $urandom, $urandom, $urandom);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'd2024);
        rst_n = 1'b0; pix_clk = 1'b0; edge_sel = 1'b0; swap_en = 1'b0; two_lane = 1'b0;
        pix_bus = '0; vsync = 1'b0; hsync = 1'b0; den = 1'b0; prev_valid = 1'b0;
        prev_frame = '0;
        repeat (3) @(negedge bit_clk);
        chk("R1 outputs in reset", {28'd0, standby, lane0, lane1, clk_out}, 32'h8);
        repeat (2) @(negedge bit_clk);
        rst_n = 1'b1;
        @(negedge bit_clk);
        chk("R1 outputs after reset", {28'd0, standby, lane0, lane1, clk_out}, 32'h8);

        // rising edge, one lane, no swap; parity corner words
        send_pix(24'h000000, 1'b0, 1'b0, 1'b0);
        send_pix(24'hFFFFFF, 1'b1, 1'b1, 1'b1);
        send_pix(24'hA5C381, 1'b1, 1'b0, 1'b1);
        rand_pixels(6);
        go_idle();

        // rising edge, two lanes, swapped bus
        two_lane = 1'b1; swap_en = 1'b1;
        send_pix(24'h000001, 1'b0, 1'b1, 1'b0);
        send_pix(24'h800000, 1'b1, 1'b0, 1'b0);
        rand_pixels(6);
        go_idle();

        // falling edge: rising edge must be ignored in standby
        edge_sel = 1'b1; two_lane = 1'b0;
        @(negedge bit_clk);
        pix_clk = 1'b1;
        wait_check_ignored("R7 rising edge ignored in falling mode");
        send_pix(24'h0F00F0, 1'b0, 1'b0, 1'b1);
        rand_pixels(6);
        go_idle();

        // falling edge, two lanes, no swap
        two_lane = 1'b1; swap_en = 1'b0;
        rand_pixels(6);
        go_idle();

        // back to rising: falling edge must be ignored
        edge_sel = 1'b0;
        @(negedge bit_clk);
        pix_clk = 1'b0;
        wait_check_ignored("R7 falling edge ignored in rising mode");
        rand_pixels(5);
        go_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule